// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block computes and holds an 8-bit condition byte for an 8-bit datapath. Each time the execution stage finishes an operation, it presents both operands, the result it produced, and a class code that names the kind of operation. On the same cycle it raises an update strobe. At the next clock edge the unit writes the flags that belong to that class into its register and keeps every other flag unchanged.

The unit derives five flags:

- a carry out of the top bit;
- a carry out of the low nibble;
- a zero flag;
- a signed overflow flag;
- a sign flag.

Each flag sits at a fixed bit of the status byte, so later stages can test a flag by its bit position. For a decrement, the two carry flags follow the "no borrow" convention. A complement or a move touches only the zero and sign flags.

Top module: `stat_flag_unit`

## Requirements
- R1: On reset, the status output reads 0x00.
- R2: Bits 7, 6 and 5 of the status output always read 0. The flag positions are: bit 0 carry, bit 1 nibble carry, bit 2 zero, bit 3 signed overflow, bit 4 negative.
- R3: For class 0 (add), bit 0 is set exactly when opnd_a + opnd_b exceeds 0xFF. For example, 0x9C + 0x64 sets it, and 0x38 + 0x2F clears it.
- R4: For class 0 (add), bit 1 is set exactly when the sum of the low nibbles of the two operands exceeds 0xF. For example, 0x38 + 0x2F sets it.
- R5: For every class, an update sets bit 2 when the result is 0x00 and clears it otherwise.
- R6: For class 0 (add), bit 3 is set exactly when both operands have the same bit 7 and the result's bit 7 differs from it. For example, 0x50 + 0x50 giving 0xA0 sets it.
- R7: For every class, an update copies result bit 7 into bit 4.
- R8: For class 1 (decrement of opnd_a), bit 0 is set when opnd_a is nonzero, and bit 1 is set when the low nibble of opnd_a is nonzero. In both cases, set means no borrow occurred.
- R9: For class 1 (decrement), bit 3 is set exactly when opnd_a is 0x80 and the result is 0x7F. More generally, it is set when a negative operand yields a non-negative result.
- R10: For class 2 (complement) and class 3 (move), bits 0, 1 and 3 keep their previous values.
- R11: While upd_en is low, the status output holds its value whatever the other inputs do.
- R12: Flags from a strobe sampled at a rising edge appear on the output right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Update strobe; the flags are written on the next rising edge |
| op_class | input | 2 | 0 add, 1 decrement, 2 complement, 3 move |
| opnd_a | input | 8 | First operand (the decremented value for class 1) |
| opnd_b | input | 8 | Second operand (used by class 0 only) |
| result | input | 8 | Result produced by the datapath |
| stat_q | output | 8 | Registered status byte |

## Verification
Every result of this unit is due exactly one rising edge after the strobe is sampled. The bench therefore changes inputs on the falling edge, drops the strobe on the following falling edge, and reads stat_q there, half a period after the capturing edge. For the latency requirement, the bench also samples stat_q a quarter period before the capturing edge to confirm the old value is still present. The hold and keep-flag requirements are judged by comparing the output against the value the bench already knows the register holds.

// File: rtl/stat_flag_pkg.sv
package stat_flag_pkg;

   typedef enum logic [1:0] {
      SF_ADD = 2'd0,
      SF_DEC = 2'd1,
      SF_CPL = 2'd2,
      SF_MOV = 2'd3
   } sf_op_e;

   // bit positions inside the status byte; downstream tests depend on them
   localparam int unsigned SF_C    = 0;
   localparam int unsigned SF_DC   = 1;
   localparam int unsigned SF_Z    = 2;
   localparam int unsigned SF_OV   = 3;
   localparam int unsigned SF_N    = 4;
   localparam int unsigned SF_USED = 5;

   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } sf_flags_t;

endpackage

// File: rtl/sf_add_eval.sv
module sf_add_eval #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DIGIT_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] r,
   output logic              c,
   output logic              dc,
   output logic              ov
);
   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W:0]  full_sum;
   logic [DIGIT_W:0] low_sum;

   always_comb begin
      full_sum = {1'b0, a} + {1'b0, b};
      low_sum  = {1'b0, a[DIGIT_W-1:0]} + {1'b0, b[DIGIT_W-1:0]};
      c        = full_sum[DATA_W];
      dc       = low_sum[DIGIT_W];
      ov       = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
   end
endmodule

// File: rtl/sf_dec_eval.sv
module sf_dec_eval #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DIGIT_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] r,
   output logic              c,
   output logic              dc,
   output logic              ov
);
   localparam int unsigned MSB = DATA_W - 1;

   always_comb begin
      // set means "no borrow": the minuend (or its low digit) was nonzero
      c  = |a;
      dc = |a[DIGIT_W-1:0];
      // subtracting one: a negative operand turning non-negative
      ov = a[MSB] & ~r[MSB];
   end
endmodule

// File: rtl/sf_reg.sv
module sf_reg #(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned USED_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [USED_W-1:0] wmask,
   input  logic [USED_W-1:0] d,
   output logic [REG_W-1:0]  q
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i < USED_W) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (en && wmask[i])
               bit_q <= d[i];
         end
         assign q[i] = bit_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
   import stat_flag_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned REG_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [1:0]        op_class,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] result,
   output logic [REG_W-1:0]  stat_q
);
   localparam int unsigned MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_data
      $error("stat_flag_unit: DATA_W must be at least 2");
   end
   if (DIGIT_W < 1 || DIGIT_W >= DATA_W) begin : g_bad_digit
      $error("stat_flag_unit: DIGIT_W must lie in 1..DATA_W-1");
   end
   if (REG_W < SF_USED) begin : g_bad_reg
      $error("stat_flag_unit: REG_W too small for the flag set");
   end

   sf_op_e    op;
   logic      add_c, add_dc, add_ov;
   logic      dec_c, dec_dc, dec_ov;
   sf_flags_t nxt;
   sf_flags_t wmask;

   assign op = sf_op_e'(op_class);

   sf_add_eval #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_add (
      .a(opnd_a), .b(opnd_b), .r(result),
      .c(add_c), .dc(add_dc), .ov(add_ov)
   );

   sf_dec_eval #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_dec (
      .a(opnd_a), .r(result),
      .c(dec_c), .dc(dec_dc), .ov(dec_ov)
   );

   always_comb begin
      nxt.z  = ~|result;
      nxt.n  = result[MSB];
      nxt.c  = 1'b0;
      nxt.dc = 1'b0;
      nxt.ov = 1'b0;
      wmask  = '{n: 1'b1, ov: 1'b0, z: 1'b1, dc: 1'b0, c: 1'b0};
      unique case (op)
         SF_ADD: begin
            nxt.c = add_c; nxt.dc = add_dc; nxt.ov = add_ov;
            wmask = '1;
         end
         SF_DEC: begin
            nxt.c = dec_c; nxt.dc = dec_dc; nxt.ov = dec_ov;
            wmask = '1;
         end
         SF_CPL, SF_MOV: ;
         default: ;
      endcase
   end

   sf_reg #(.REG_W(REG_W), .USED_W(SF_USED)) u_reg (
      .clk(clk), .rst_n(rst_n), .en(upd_en),
      .wmask(wmask), .d(nxt), .q(stat_q)
   );
endmodule

// File: rtl/stat_flag_chk.sv
module stat_flag_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [1:0]        op_class,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] result,
   input logic [REG_W-1:0]  stat_q
);
   logic [DATA_W:0] wide_sum;
   assign wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[REG_W-1:5] == '0);

   p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_class == 2'd0) |=> stat_q[0] == $past(wide_sum[DATA_W]));

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> stat_q[2] == ($past(result) == '0));

   p_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> stat_q[4] == $past(result[DATA_W-1]));

   p_keep_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_class[1]) |=>
         (stat_q[1:0] == $past(stat_q[1:0])) && (stat_q[3] == $past(stat_q[3])));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(stat_q));
endmodule

bind stat_flag_unit stat_flag_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .stat_q(stat_q)
);

// File: tb/stat_flag_unit_test.sv
module stat_flag_unit_test;
   localparam int NV = 14;

   // {class, a, b, result, expected status}
   localparam logic [33:0] VEC [NV] = '{
      {2'd0, 8'h38, 8'h2F, 8'h67, 8'h02},
      {2'd0, 8'h9C, 8'h64, 8'h00, 8'h07},
      {2'd0, 8'h50, 8'h50, 8'hA0, 8'h18},
      {2'd2, 8'hA0, 8'h00, 8'h5F, 8'h08},
      {2'd3, 8'h00, 8'h00, 8'h00, 8'h0C},
      {2'd1, 8'h80, 8'h00, 8'h7F, 8'h09},
      {2'd1, 8'h01, 8'h00, 8'h00, 8'h07},
      {2'd1, 8'h00, 8'h00, 8'hFF, 8'h10},
      {2'd0, 8'hFF, 8'h01, 8'h00, 8'h07},
      {2'd3, 8'h80, 8'h00, 8'h80, 8'h13},
      {2'd0, 8'h80, 8'h80, 8'h00, 8'h0D},
      {2'd2, 8'hFF, 8'h00, 8'h00, 8'h0D},
      {2'd0, 8'h0F, 8'h01, 8'h10, 8'h02},
      {2'd1, 8'h10, 8'h00, 8'h0F, 8'h01}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_en = 1'b0;
   logic [1:0] op_class = 2'd0;
   logic [7:0] opnd_a = '0, opnd_b = '0, result = '0;
   logic [7:0] stat_q;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   stat_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .stat_q(stat_q)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   function automatic string flag_tag(input logic [1:0] op, input int bitpos);
      if (op[1] && (bitpos == 0 || bitpos == 1 || bitpos == 3)) return "R10";
      case (bitpos)
         0: return (op == 2'd1) ? "R8" : "R3";
         1: return (op == 2'd1) ? "R8" : "R4";
         2: return "R5";
         3: return (op == 2'd1) ? "R9" : "R6";
         4: return "R7";
         default: return "R2";
      endcase
   endfunction

   task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] r);
      @(negedge clk);
      op_class = op; opnd_a = a; opnd_b = b; result = r; upd_en = 1'b1;
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", stat_q, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", stat_q, 8'h00);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
         for (int k = 0; k < 8; k++)
            check(flag_tag(VEC[i][33:32], k), {7'd0, stat_q[k]}, {7'd0, VEC[i][k]});
      end

      // R11: inputs move without a strobe; register holds 0x01
      @(negedge clk);
      op_class = 2'd0; opnd_a = 8'hFF; opnd_b = 8'hFF; result = 8'hFE;
      repeat (3) @(negedge clk);
      check("R11", stat_q, 8'h01);

      // R12: strobe an add of 0x9C + 0x64; old value until the edge
      @(negedge clk);
      op_class = 2'd0; opnd_a = 8'h9C; opnd_b = 8'h64; result = 8'h00; upd_en = 1'b1;
      #1;
      check("R12", stat_q, 8'h01);
      @(negedge clk);
      upd_en = 1'b0;
      check("R12", stat_q, 8'h07);

      // R10: complement after an overflowing add keeps C, DC, OV
      apply(2'd0, 8'h7F, 8'h01, 8'h80);
      check("R6", stat_q, 8'h1A);
      apply(2'd2, 8'h80, 8'h00, 8'h7F);
      check("R10", stat_q, 8'h0A);

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", stat_q, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", stat_q & 8'hE0, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule